// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Model

This block is a synthesizable functional model of a synchronous SRAM that moves two data words per access. It runs on a single system clock. The two halves of each double-rate clock period appear as two parallel word ports. Port 0 carries the word that would arrive on the rising edge, and port 1 carries the word that would arrive on the opposite-phase edge.

A controller starts an access by presenting an address with the active-low command enable in a given cycle. On a write, it supplies both words with their active-low lane masks in the next cycle. On a read, both words of the pair come back together a fixed number of cycles later, flagged by a valid and an output-enable signal.

The block stores each aligned pair of words as one wide entry. The lowest address bit selects which word of the pair comes first, and the burst wraps inside the pair. A read issued directly after a write to the same pair sees the new data. A write requested directly after a read is dropped.

Top module: `burst2_ddr_sram`

## Requirements
- R1: A command is taken only when `cmd_en_n` is low at a clock edge: `cmd_read` = 1 starts a read and 0 starts a write. While `cmd_en_n` is high, `cmd_read`, `cmd_addr` and the write ports cause neither a read response nor a change to memory.
- R2: Write data for a write accepted at edge e is taken from `wr_word0`/`wr_mask0_n` (first word) and `wr_word1`/`wr_mask1_n` (second word) at edge e+1. At other edges those ports are ignored.
- R3: Mask bits are active low, one per lane, and apply to each word separately. Lane l covers bits [l*LANE_W +: LANE_W] of a word. A lane whose mask bit is 1 keeps its previous stored value.
- R4: Bit 0 of `cmd_addr` picks the starting word of the pair, and the upper bits pick the pair. With bit 0 = 0, the first word is word 0 and the second is word 1. With bit 0 = 1 the order is reversed, for both writes and reads. The upper bits are never changed by the burst.
- R5: For a read accepted at edge e, `rd_word0` (first word) and `rd_word1` (second word) are presented after edge e+RD_LAT. `rd_valid` is high for exactly that one cycle per read.
- R6: A read accepted at the edge right after a write to the same pair returns the newly written lanes, merged with the stored lanes that the write did not enable.
- R7: A write requested at the edge directly after an accepted read is discarded and changes no memory.
- R8: `rd_oe` equals `rd_valid`. Whenever no read data is presented, including after reset, `rd_valid`, `rd_oe`, `rd_word0` and `rd_word1` are all zero.
- R9: A read already accepted completes on schedule even if `cmd_en_n` is high at the following edges.
- R10: Reads accepted on consecutive edges return their pairs on consecutive cycles with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_en_n | input | 1 | Active-low command enable |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | ADDR_W | Pair index in upper bits, start word in bit 0 |
| wr_mask0_n | input | LANES | Active-low lane mask, first write word |
| wr_word0 | input | LANES*LANE_W | First write word |
| wr_mask1_n | input | LANES | Active-low lane mask, second write word |
| wr_word1 | input | LANES*LANE_W | Second write word |
| rd_valid | output | 1 | Read data present |
| rd_oe | output | 1 | Output drive enable |
| rd_word0 | output | LANES*LANE_W | First read word |
| rd_word1 | output | LANES*LANE_W | Second read word |

## Verification
The bench builds the block with six address bits (32 pairs), two 9-bit lanes and a read latency of 3. The latency of 3 exercises the extra delay stage of the read pipeline rather than only the shortest path. Random traffic is confined to four pairs, so same-pair write-then-read forwarding, dropped writes after reads, and partial-lane overwrites occur often. Directed sequences then pin down reversed start words, masks that differ between the two words, and deselects behind a read.

// File: rtl/burst2_pkg.sv
package burst2_pkg;
  localparam int MIN_RD_LAT = 2;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;
endpackage

// File: rtl/burst2_cmd.sv
module burst2_cmd
  import burst2_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_en_n,
  input  logic              cmd_read,
  input  logic [ADDR_W-1:0] cmd_addr,
  output cmd_e              cmd_q,
  output logic [ADDR_W-1:0] addr_q
);
  // A write directly behind an accepted read turns into an idle slot.
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= CMD_IDLE;
      addr_q <= '0;
    end else begin
      addr_q <= cmd_addr;
      if (cmd_en_n)
        cmd_q <= CMD_IDLE;
      else if (cmd_read)
        cmd_q <= CMD_READ;
      else if (cmd_q == CMD_READ)
        cmd_q <= CMD_IDLE;
      else
        cmd_q <= CMD_WRITE;
    end
  end

  p_deselect_idle_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_en_n |=> cmd_q == CMD_IDLE);
endmodule

// File: rtl/burst2_wcap.sv
module burst2_wcap #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int W      = LANES * LANE_W,
  localparam int PAIR_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_v,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [LANES-1:0]  mask0_n,
  input  logic [W-1:0]      word0,
  input  logic [LANES-1:0]  mask1_n,
  input  logic [W-1:0]      word1,
  output logic              wq_v,
  output logic [PAIR_W-1:0] wq_pair,
  output logic [2*W-1:0]    wq_data,
  output logic [2*LANES-1:0] wq_en
);
  // Stored layout: word 0 in the low half, word 1 in the high half.
  always_ff @(posedge clk) begin
    if (rst) begin
      wq_v    <= 1'b0;
      wq_pair <= '0;
      wq_data <= '0;
      wq_en   <= '0;
    end else begin
      wq_v <= wr_v;
      if (wr_v) begin
        wq_pair <= addr_q[ADDR_W-1:1];
        if (addr_q[0]) begin
          wq_data <= {word0, word1};
          wq_en   <= {~mask0_n, ~mask1_n};
        end else begin
          wq_data <= {word1, word0};
          wq_en   <= {~mask1_n, ~mask0_n};
        end
      end
    end
  end
endmodule

// File: rtl/burst2_array.sv
module burst2_array #(
  parameter int PAIR_W = 5,
  parameter int LANE_W = 9,
  parameter int NLANE  = 4,
  localparam int DEPTH = 1 << PAIR_W
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [PAIR_W-1:0]       wpair,
  input  logic [NLANE*LANE_W-1:0] wdata,
  input  logic [NLANE-1:0]        wen,
  input  logic                    re,
  input  logic [PAIR_W-1:0]       rpair,
  output logic [NLANE*LANE_W-1:0] rdata
);
  // One narrow RAM per lane keeps the lane write enable a plain RAM write port.
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q_l;

    always_ff @(posedge clk) begin
      if (we && wen[g])
        mem[wpair] <= wdata[g*LANE_W +: LANE_W];
      if (re)
        q_l <= mem[rpair];
    end

    assign rdata[g*LANE_W +: LANE_W] = q_l;
  end
endmodule

// File: rtl/burst2_rdpath.sv
module burst2_rdpath #(
  parameter int PAIR_W = 5,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  parameter int RD_LAT = 2,
  localparam int W     = LANES * LANE_W,
  localparam int NLANE = 2 * LANES,
  localparam int NST   = RD_LAT - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_v,
  input  logic              word_sel,
  input  logic [PAIR_W-1:0] rpair,
  input  logic              wq_v,
  input  logic [PAIR_W-1:0] wq_pair,
  input  logic [2*W-1:0]    wq_data,
  input  logic [NLANE-1:0]  wq_en,
  input  logic [2*W-1:0]    mem_q,
  output logic              rd_valid,
  output logic              rd_oe,
  output logic [W-1:0]      rd_q0,
  output logic [W-1:0]      rd_q1
);
  logic             ra_v, ra_word, fw_hit;
  logic [2*W-1:0]   fw_data, merged;
  logic [NLANE-1:0] fw_en;
  logic [W-1:0]     first_w, second_w;

  // The pending write lands in the array on the same edge as this read,
  // so its enabled lanes are kept here and merged over the old contents.
  always_ff @(posedge clk) begin
    if (rst) begin
      ra_v    <= 1'b0;
      ra_word <= 1'b0;
      fw_hit  <= 1'b0;
      fw_data <= '0;
      fw_en   <= '0;
    end else begin
      ra_v    <= rd_v;
      ra_word <= word_sel;
      fw_hit  <= rd_v && wq_v && (wq_pair == rpair);
      fw_data <= wq_data;
      fw_en   <= wq_en;
    end
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = (fw_hit && fw_en[g]) ?
      fw_data[g*LANE_W +: LANE_W] : mem_q[g*LANE_W +: LANE_W];
  end

  assign first_w  = ra_word ? merged[2*W-1:W] : merged[W-1:0];
  assign second_w = ra_word ? merged[W-1:0]   : merged[2*W-1:W];

  logic         st_v  [NST];
  logic [W-1:0] st_q0 [NST];
  logic [W-1:0] st_q1 [NST];
  logic         oe_src, oe_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NST; i++) begin
        st_v[i]  <= 1'b0;
        st_q0[i] <= '0;
        st_q1[i] <= '0;
      end
    end else begin
      st_v[0]  <= ra_v;
      st_q0[0] <= ra_v ? first_w  : '0;
      st_q1[0] <= ra_v ? second_w : '0;
      for (int i = 1; i < NST; i++) begin
        st_v[i]  <= st_v[i-1];
        st_q0[i] <= st_q0[i-1];
        st_q1[i] <= st_q1[i-1];
      end
    end
  end

  if (NST == 1) begin : g_oe_short
    assign oe_src = ra_v;
  end else begin : g_oe_long
    assign oe_src = st_v[NST-2];
  end

  // Duplicate register for the drive enable, as an output-cell copy.
  always_ff @(posedge clk) begin
    if (rst) oe_r <= 1'b0;
    else     oe_r <= oe_src;
  end

  assign rd_valid = st_v[NST-1];
  assign rd_q0    = st_q0[NST-1];
  assign rd_q1    = st_q1[NST-1];
  assign rd_oe    = oe_r;

  p_quiet_bus_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_q0 == '0 && rd_q1 == '0));
  p_oe_tracks_valid_r8: assert property (@(posedge clk) disable iff (rst)
    rd_oe == rd_valid);
  p_read_advances_r9: assert property (@(posedge clk) disable iff (rst)
    ra_v |=> st_v[0]);
endmodule

// File: rtl/burst2_ddr_sram.sv
module burst2_ddr_sram
  import burst2_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  parameter int RD_LAT = 2,
  localparam int W      = LANES * LANE_W,
  localparam int PAIR_W = ADDR_W - 1,
  localparam int NLANE  = 2 * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_en_n,
  input  logic              cmd_read,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LANES-1:0]  wr_mask0_n,
  input  logic [W-1:0]      wr_word0,
  input  logic [LANES-1:0]  wr_mask1_n,
  input  logic [W-1:0]      wr_word1,
  output logic              rd_valid,
  output logic              rd_oe,
  output logic [W-1:0]      rd_word0,
  output logic [W-1:0]      rd_word1
);
  cmd_e              cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_v, wr_v;
  logic              wq_v;
  logic [PAIR_W-1:0] wq_pair;
  logic [2*W-1:0]    wq_data, mem_q;
  logic [NLANE-1:0]  wq_en;

  initial begin
    assert (RD_LAT >= MIN_RD_LAT);
    assert (ADDR_W >= 2);
  end

  burst2_cmd #(.ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst(rst), .cmd_en_n(cmd_en_n), .cmd_read(cmd_read),
    .cmd_addr(cmd_addr), .cmd_q(cmd_q), .addr_q(addr_q)
  );

  assign rd_v = (cmd_q == CMD_READ);
  assign wr_v = (cmd_q == CMD_WRITE);

  burst2_wcap #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wcap (
    .clk(clk), .rst(rst), .wr_v(wr_v), .addr_q(addr_q),
    .mask0_n(wr_mask0_n), .word0(wr_word0),
    .mask1_n(wr_mask1_n), .word1(wr_word1),
    .wq_v(wq_v), .wq_pair(wq_pair), .wq_data(wq_data), .wq_en(wq_en)
  );

  burst2_array #(.PAIR_W(PAIR_W), .LANE_W(LANE_W), .NLANE(NLANE)) u_array (
    .clk(clk), .we(wq_v), .wpair(wq_pair), .wdata(wq_data), .wen(wq_en),
    .re(rd_v), .rpair(addr_q[ADDR_W-1:1]), .rdata(mem_q)
  );

  burst2_rdpath #(.PAIR_W(PAIR_W), .LANES(LANES), .LANE_W(LANE_W),
                  .RD_LAT(RD_LAT)) u_rdpath (
    .clk(clk), .rst(rst), .rd_v(rd_v), .word_sel(addr_q[0]),
    .rpair(addr_q[ADDR_W-1:1]), .wq_v(wq_v), .wq_pair(wq_pair),
    .wq_data(wq_data), .wq_en(wq_en), .mem_q(mem_q),
    .rd_valid(rd_valid), .rd_oe(rd_oe), .rd_q0(rd_word0), .rd_q1(rd_word1)
  );

  p_wdata_follows_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_q == CMD_WRITE |=> wq_v);
  p_write_dropped_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_q == CMD_READ |=> ##1 !wq_v);
endmodule

// File: tb/burst2_ddr_sram_tb.sv
module burst2_ddr_sram_tb;
  localparam int ADDR_W = 6;
  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int RD_LAT = 3;
  localparam int W      = LANES * LANE_W;
  localparam int PAIR_W = ADDR_W - 1;
  localparam int DEPTH  = 1 << PAIR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_en_n = 1'b1, cmd_read = 1'b0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [LANES-1:0] wr_mask0_n = '1, wr_mask1_n = '1;
  logic [W-1:0] wr_word0 = '0, wr_word1 = '0;
  logic rd_valid, rd_oe;
  logic [W-1:0] rd_word0, rd_word1;

  always #10 clk = ~clk;

  burst2_ddr_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W),
                    .RD_LAT(RD_LAT)) u_dut (
    .clk(clk), .rst(rst), .cmd_en_n(cmd_en_n), .cmd_read(cmd_read),
    .cmd_addr(cmd_addr), .wr_mask0_n(wr_mask0_n), .wr_word0(wr_word0),
    .wr_mask1_n(wr_mask1_n), .wr_word1(wr_word1), .rd_valid(rd_valid),
    .rd_oe(rd_oe), .rd_word0(rd_word0), .rd_word1(rd_word1)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  logic [W-1:0] ref_w [DEPTH][2];
  logic              m_pw_v = 0, m_prev_rd = 0, m_pw_word = 0;
  logic [PAIR_W-1:0] m_pw_pair = '0;
  logic              s_v  [8];
  logic [W-1:0]      s_q0 [8];
  logic [W-1:0]      s_q1 [8];
  string             s_tag[8];

  function automatic logic [W-1:0] merge(input logic [W-1:0] old_w,
      input logic [W-1:0] new_w, input logic [LANES-1:0] m_n);
    logic [W-1:0] r = old_w;
    for (int l = 0; l < LANES; l++)
      if (!m_n[l]) r[l*LANE_W +: LANE_W] = new_w[l*LANE_W +: LANE_W];
    return r;
  endfunction

  function automatic logic [W-1:0] pat(input int p, input int w);
    return W'((p * 7919 + w * 2713 + 305) ^ (p << 9));
  endfunction

  task automatic fail_line(input string tag, input string what,
                           input logic [W-1:0] act, input logic [W-1:0] exp);
    n_bad++;
    $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cyc);
  endtask

  task automatic check_now(input string cur_tag);
    int i = cyc % 8;
    string t = s_v[i] ? s_tag[i] : cur_tag;
    n_chk++;
    if (rd_valid !== s_v[i]) fail_line(t, "rd_valid", W'(rd_valid), W'(s_v[i]));
    else if (rd_oe !== s_v[i]) fail_line(t, "rd_oe", W'(rd_oe), W'(s_v[i]));
    else if (rd_word0 !== s_q0[i]) fail_line(t, "rd_word0", rd_word0, s_q0[i]);
    else if (rd_word1 !== s_q1[i]) fail_line(t, "rd_word1", rd_word1, s_q1[i]);
    s_v[i] = 0; s_q0[i] = '0; s_q1[i] = '0;
  endtask

  // Drive one edge: command for this edge, write ports for last edge's write.
  task automatic step(input logic en_n, input logic rd, input logic [ADDR_W-1:0] a,
                      input logic [LANES-1:0] m0, input logic [W-1:0] x0,
                      input logic [LANES-1:0] m1, input logic [W-1:0] x1,
                      input string tag);
    int k;
    logic [PAIR_W-1:0] pr;
    cmd_en_n = en_n; cmd_read = rd; cmd_addr = a;
    wr_mask0_n = m0; wr_word0 = x0; wr_mask1_n = m1; wr_word1 = x1;
    if (m_pw_v) begin
      ref_w[m_pw_pair][m_pw_word]  = merge(ref_w[m_pw_pair][m_pw_word], x0, m0);
      ref_w[m_pw_pair][!m_pw_word] = merge(ref_w[m_pw_pair][!m_pw_word], x1, m1);
    end
    m_pw_v = 0;
    k = cyc + 1;
    pr = a[ADDR_W-1:1];
    if (!en_n) begin
      if (rd) begin
        s_v[(k+RD_LAT)%8]   = 1;
        s_q0[(k+RD_LAT)%8]  = ref_w[pr][a[0]];
        s_q1[(k+RD_LAT)%8]  = ref_w[pr][!a[0]];
        s_tag[(k+RD_LAT)%8] = tag;
        m_prev_rd = 1;
      end else begin
        if (!m_prev_rd) begin
          m_pw_v = 1; m_pw_pair = pr; m_pw_word = a[0];
        end
        m_prev_rd = 0;
      end
    end else m_prev_rd = 0;
    @(negedge clk);
    cyc++;
    check_now(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, $urandom%2, ADDR_W'($urandom), '0, W'($urandom), '0, W'($urandom), tag);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) begin s_v[i] = 0; s_q0[i] = '0; s_q1[i] = '0; s_tag[i] = ""; end
    for (int p = 0; p < DEPTH; p++) begin ref_w[p][0] = '0; ref_w[p][1] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check_now("R8 reset state");

    // Fill every pair, full masks; data for pair p rides the step after it.
    for (int p = 0; p <= DEPTH; p++)
      step(p < DEPTH ? 1'b0 : 1'b1, 0, {PAIR_W'(p), 1'b0}, '0, pat(p-1, 0), '0, pat(p-1, 1), "R2 fill");
    for (int p = 0; p < DEPTH; p++) begin
      ref_w[p][0] = pat(p, 0); ref_w[p][1] = pat(p, 1);
    end
    // Back-to-back reads from word 0 (R10, R5).
    for (int p = 0; p < DEPTH; p++)
      step(0, 1, {PAIR_W'(p), 1'b0}, '0, '0, '0, '0, "R10 back-to-back R5");
    idle(4, "R8 idle");
    // Reversed start word on read (R4).
    step(0, 1, {PAIR_W'(3), 1'b1}, '0, '0, '0, '0, "R4 read start word 1");
    idle(4, "R8 idle");
    // Write starting at word 1 then read from word 0 (R4).
    step(0, 0, {PAIR_W'(5), 1'b1}, '0, '0, '0, '0, "R4 write start word 1");
    step(1, 0, '0, '0, 18'h2AAAA, '0, 18'h15555, "R4 write data");
    step(0, 1, {PAIR_W'(5), 1'b0}, '1, '0, '1, '0, "R4 readback");
    idle(4, "R8 idle");
    // Per-word lane masks (R3): word 0 lane 0 only, word 1 lane 1 only.
    step(0, 0, {PAIR_W'(6), 1'b0}, '0, '0, '0, '0, "R3 masked write");
    step(1, 0, '0, 2'b10, 18'h3FFFF, 2'b01, 18'h3FFFF, "R3 masked data");
    step(1, 0, '0, '0, '0, '0, '0, "R3 gap");
    step(0, 1, {PAIR_W'(6), 1'b0}, '0, '0, '0, '0, "R3 readback");
    idle(4, "R8 idle");
    // Forwarding with partial masks (R6).
    step(0, 0, {PAIR_W'(7), 1'b0}, '0, '0, '0, '0, "R6 write");
    step(0, 1, {PAIR_W'(7), 1'b1}, 2'b01, 18'h12345, 2'b10, 18'h0ABCD, "R6 forwarded read");
    step(0, 1, {PAIR_W'(7), 1'b0}, '0, '0, '0, '0, "R6 read again");
    idle(4, "R8 idle");
    // Write right after read is dropped (R7).
    step(0, 1, {PAIR_W'(8), 1'b0}, '0, '0, '0, '0, "R7 read");
    step(0, 0, {PAIR_W'(8), 1'b0}, '0, '0, '0, '0, "R7 write dropped");
    step(1, 0, '0, '0, 18'h00F0F, '0, 18'h0F0F0, "R7 data ignored");
    step(0, 1, {PAIR_W'(8), 1'b0}, '0, '0, '0, '0, "R7 readback");
    idle(4, "R8 idle");
    // Deselected edges are ignored (R1), read in flight completes (R9).
    step(1, 0, {PAIR_W'(9), 1'b0}, '0, '0, '0, '0, "R1 deselected write");
    step(1, 1, {PAIR_W'(9), 1'b0}, '0, 18'h3C3C3, '0, 18'h1E1E1, "R1 data ignored");
    step(0, 1, {PAIR_W'(9), 1'b0}, '0, '0, '0, '0, "R1 readback R9");
    idle(5, "R9 deselect behind read");
    // Constrained random over four pairs.
    for (int i = 0; i < 600; i++) begin
      logic [PAIR_W-1:0] rp = PAIR_W'($urandom % 4);
      step(($urandom % 4) == 0, $urandom % 2, {rp, 1'($urandom)},
           LANES'($urandom), W'($urandom), LANES'($urandom), W'($urandom),
           "R3 R4 R6 R7 random");
    end
    idle(6, "R8 drain");
    done = 1;
    summary();
  end
endmodule